// File: doc/BRIEF.md
# Event-Selectable Performance Counter Unit

This block holds a small bank of 32-bit event counters that a core samples through a word-addressed register bus. The core drives a set of event groups, each group being sixteen sub-event strobes. Every counter has its own control word that names one group and gives a sixteen-bit mask. In any cycle where at least one masked strobe of that group is high, and counting is allowed, the counter steps by one.

Software preloads a counter with the two's complement of a sampling period so that the wrap from all-ones to zero marks the period's end. The wrap latches a sticky overflow flag and, when the counter's interrupt enable is set, a sticky interrupt flag; both are cleared by writing ones to the status word. A single interrupt line is the OR of all interrupt flags. One select code does not name a group: it makes a counter step on each wrap of its lower neighbour, so two counters form a 64-bit chain.

A global enable gates every counter. A per-counter kernel bit decides whether counting continues while the core reports kernel mode; in user mode counting is always allowed. The trace-level field is stored and read back but drives nothing.

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset every counter value, control word, status word and the global enable read as 0, and irq_o is 0.
- R2: While bit 0 of the global word (offset 0x000) is 0, no counter advances.
- R3: A counter adds exactly one per cycle when the OR over (strobes of the group in control bits 12:8, AND the mask in control bits 31:16) is 1; group g occupies evt_i[16g+15:16g]; a strobe outside the mask or in another group does not count.
- R4: With kernel_mode_i high, a counter advances only if control bit 3 is 1; with kernel_mode_i low it advances regardless of bit 3.
- R5: Select code 1 makes counter i step on each cycle where counter i-1 wraps; counter 0 with code 1 never advances, and group 1 strobes are never counted.
- R6: A wrap from 0xFFFFFFFF to 0 sets status bit 0; if control bit 0 is 1 it also sets status bit 4.
- R7: Writing a status word clears bit 0 and bit 4 only where the written data has a 1; a flag set in the same cycle stays set.
- R8: irq_o is 1 exactly while some counter's status bit 4 is 1.
- R9: A software write to a counter value in the same cycle as an increment stores the written value, and no wrap is recorded from that cycle.
- R10: Writing 0 to a control word stops that counter with its value kept; control readback shows only bits 0, 3, 12:4 and 31:16 (mask 0xFFFF1FF9).
- R11: Values sit at 0x080+4i, control at 0x100+4i, status at 0x180+4i; read data appears on rdata_o one cycle after the request, and an unmapped or out-of-range word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_GRP*16 | Sub-event strobes, sixteen per group |
| kernel_mode_i | input | 1 | Core is in kernel mode |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Access is a write |
| addr_i | input | 9 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after a read request |
| irq_o | output | 1 | Combined interrupt |

## Verification
The software value write and the hardware increment can land on the same counter in one cycle. The bench provokes this by raising a counted strobe on the very cycle a value write is issued, once mid-count and once with the counter at 0xFFFFFFFF, and judges it by reading back exactly the written value and a status word with no overflow flag. The mask and strobe sweep around it fixes the count expected in every other cycle, so any stray extra step shows up in the readback.

// File: rtl/perf_pkg.sv
package perf_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned SUB_W   = 16;
  localparam int unsigned SEL_W   = 5;
  localparam int unsigned ADDR_W  = 9;
  localparam int unsigned IDX_W   = ADDR_W - 4;

  localparam logic [1:0] RGN_GLB  = 2'd0;
  localparam logic [1:0] RGN_VAL  = 2'd1;
  localparam logic [1:0] RGN_CTRL = 2'd2;
  localparam logic [1:0] RGN_STAT = 2'd3;

  localparam logic [SEL_W-1:0] SEL_CHAIN = SEL_W'(1);
  localparam logic [REG_W-1:0] CTRL_WMASK = 32'hFFFF_1FF9;
  localparam int unsigned STAT_OVF = 0;
  localparam int unsigned STAT_IRQ = 4;

  typedef struct packed {
    logic [SUB_W-1:0] mask;
    logic [2:0]       rsv_hi;
    logic [SEL_W-1:0] sel;
    logic [3:0]       trace;
    logic             kern;
    logic [1:0]       rsv_lo;
    logic             inten;
  } ctrl_t;
endpackage

// File: rtl/perf_evt_sel.sv
module perf_evt_sel
  import perf_pkg::*;
#(
  parameter int unsigned NUM_GRP = 16
) (
  input  logic [NUM_GRP*SUB_W-1:0] evt_i,
  input  logic [SEL_W-1:0]         sel_i,
  input  logic [SUB_W-1:0]         mask_i,
  input  logic                     chain_i,
  output logic                     hit_o
);
  localparam int unsigned NUM_CODE = 1 << SEL_W;

  logic [NUM_CODE-1:0] grp_hit;

  for (genvar g = 0; g < NUM_CODE; g++) begin : g_grp
    if (g < NUM_GRP) begin : g_used
      assign grp_hit[g] = |(evt_i[g*SUB_W +: SUB_W] & mask_i);
    end else begin : g_pad
      assign grp_hit[g] = 1'b0;
    end
  end

  // code 1 is the neighbour chain, never a strobe group
  assign hit_o = (sel_i == SEL_CHAIN) ? chain_i : grp_hit[sel_i];
endmodule

// File: rtl/perf_ctr_slot.sv
module perf_ctr_slot
  import perf_pkg::*;
#(
  parameter int unsigned NUM_GRP = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     glb_en_i,
  input  logic                     kernel_i,
  input  logic [NUM_GRP*SUB_W-1:0] evt_i,
  input  logic                     chain_i,
  input  logic                     val_we_i,
  input  logic                     ctrl_we_i,
  input  logic                     stat_we_i,
  input  logic [REG_W-1:0]         wdata_i,
  output logic [REG_W-1:0]         cnt_o,
  output logic [REG_W-1:0]         ctrl_o,
  output logic [REG_W-1:0]         stat_o,
  output logic                     wrap_o,
  output logic                     irq_o
);
  ctrl_t            ctrl_q;
  logic [REG_W-1:0] cnt_q;
  logic             ovf_q, irqf_q;
  logic             hit, priv_ok, inc, wrap;

  perf_evt_sel #(.NUM_GRP(NUM_GRP)) u_sel (
    .evt_i  (evt_i),
    .sel_i  (ctrl_q.sel),
    .mask_i (ctrl_q.mask),
    .chain_i(chain_i),
    .hit_o  (hit)
  );

  assign priv_ok = ~kernel_i | ctrl_q.kern;
  assign inc     = glb_en_i & hit & priv_ok;
  // a value write in the same cycle takes precedence and hides the wrap
  assign wrap    = inc & ~val_we_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      irqf_q <= 1'b0;
    end else begin
      if (ctrl_we_i) ctrl_q <= ctrl_t'(wdata_i & CTRL_WMASK);
      if (val_we_i)  cnt_q  <= wdata_i;
      else if (inc)  cnt_q  <= cnt_q + REG_W'(1);
      ovf_q  <= wrap | (ovf_q & ~(stat_we_i & wdata_i[STAT_OVF]));
      irqf_q <= (wrap & ctrl_q.inten) | (irqf_q & ~(stat_we_i & wdata_i[STAT_IRQ]));
    end
  end

  assign cnt_o  = cnt_q;
  assign ctrl_o = ctrl_q;
  assign stat_o = {{(REG_W-STAT_IRQ-1){1'b0}}, irqf_q, {(STAT_IRQ-STAT_OVF-1){1'b0}}, ovf_q};
  assign wrap_o = wrap;
  assign irq_o  = irqf_q;
endmodule

// File: rtl/perf_regif.sv
module perf_regif
  import perf_pkg::*;
#(
  parameter int unsigned NUM_CTR = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [REG_W-1:0]         wdata_i,
  input  logic [NUM_CTR*REG_W-1:0] cnt_i,
  input  logic [NUM_CTR*REG_W-1:0] ctrl_i,
  input  logic [NUM_CTR*REG_W-1:0] stat_i,
  output logic                     glb_en_o,
  output logic [NUM_CTR-1:0]       val_we_o,
  output logic [NUM_CTR-1:0]       ctrl_we_o,
  output logic [NUM_CTR-1:0]       stat_we_o,
  output logic [REG_W-1:0]         rdata_o
);
  logic [1:0]       region;
  logic [IDX_W-1:0] idx;
  logic             aligned, wr, rd;
  logic             glb_q;
  logic [REG_W-1:0] rd_d, rdata_q;

  assign region  = addr_i[ADDR_W-1 -: 2];
  assign idx     = addr_i[ADDR_W-3:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign wr      = req_i & we_i & aligned;
  assign rd      = req_i & ~we_i;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_dec
    assign val_we_o[i]  = wr && region == RGN_VAL  && idx == IDX_W'(i);
    assign ctrl_we_o[i] = wr && region == RGN_CTRL && idx == IDX_W'(i);
    assign stat_we_o[i] = wr && region == RGN_STAT && idx == IDX_W'(i);
  end

  always_comb begin
    rd_d = '0;
    if (aligned) begin
      if (region == RGN_GLB) begin
        if (idx == '0) rd_d = {{(REG_W-1){1'b0}}, glb_q};
      end else begin
        for (int i = 0; i < NUM_CTR; i++) begin
          if (idx == IDX_W'(i)) begin
            case (region)
              RGN_VAL:  rd_d = cnt_i[i*REG_W +: REG_W];
              RGN_CTRL: rd_d = ctrl_i[i*REG_W +: REG_W];
              default:  rd_d = stat_i[i*REG_W +: REG_W];
            endcase
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr && region == RGN_GLB && idx == '0) glb_q <= wdata_i[0];
      if (rd) rdata_q <= rd_d;
    end
  end

  assign glb_en_o = glb_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank
  import perf_pkg::*;
#(
  parameter int unsigned NUM_CTR = 4,
  parameter int unsigned NUM_GRP = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_GRP*SUB_W-1:0] evt_i,
  input  logic                     kernel_mode_i,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [REG_W-1:0]         wdata_i,
  output logic [REG_W-1:0]         rdata_o,
  output logic                     irq_o
);
  logic                     glb_en;
  logic [NUM_CTR-1:0]       val_we, ctrl_we, stat_we;
  logic [NUM_CTR*REG_W-1:0] cnt_flat, ctrl_flat, stat_flat;
  logic [NUM_CTR-1:0]       wrap_vec, irq_vec, ovf_vec;
  logic [NUM_CTR:0]         chain;

  perf_regif #(.NUM_CTR(NUM_CTR)) u_regif (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .cnt_i    (cnt_flat),
    .ctrl_i   (ctrl_flat),
    .stat_i   (stat_flat),
    .glb_en_o (glb_en),
    .val_we_o (val_we),
    .ctrl_we_o(ctrl_we),
    .stat_we_o(stat_we),
    .rdata_o  (rdata_o)
  );

  // counter 0 has no lower neighbour
  assign chain[0] = 1'b0;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_slot
    perf_ctr_slot #(.NUM_GRP(NUM_GRP)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .glb_en_i (glb_en),
      .kernel_i (kernel_mode_i),
      .evt_i    (evt_i),
      .chain_i  (chain[i]),
      .val_we_i (val_we[i]),
      .ctrl_we_i(ctrl_we[i]),
      .stat_we_i(stat_we[i]),
      .wdata_i  (wdata_i),
      .cnt_o    (cnt_flat[i*REG_W +: REG_W]),
      .ctrl_o   (ctrl_flat[i*REG_W +: REG_W]),
      .stat_o   (stat_flat[i*REG_W +: REG_W]),
      .wrap_o   (wrap_vec[i]),
      .irq_o    (irq_vec[i])
    );
    assign chain[i+1] = wrap_vec[i];
    assign ovf_vec[i] = stat_flat[i*REG_W + STAT_OVF];
  end

  assign irq_o = |irq_vec;
endmodule

// File: rtl/perf_ctr_bank_chk.sv
module perf_ctr_bank_chk #(
  parameter int unsigned NUM_CTR = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  glb_en_i,
  input logic [NUM_CTR-1:0]    val_we_i,
  input logic [NUM_CTR*32-1:0] cnt_i,
  input logic [NUM_CTR-1:0]    ovf_i,
  input logic [NUM_CTR-1:0]    irqf_i
);
  // R2: disabled bank holds every count unless software writes it
  a_r2_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glb_en_i && val_we_i == '0) |=> $stable(cnt_i));

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    // R3: a counter moves by at most one per cycle
    a_r3_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !val_we_i[i] |=> (cnt_i[i*32 +: 32] == $past(cnt_i[i*32 +: 32]) ||
                        cnt_i[i*32 +: 32] == $past(cnt_i[i*32 +: 32]) + 32'd1));
    // R6: leaving all-ones without a write leaves the overflow flag set
    a_r6_wrap_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!val_we_i[i] && cnt_i[i*32 +: 32] == 32'hFFFF_FFFF)
      |=> (cnt_i[i*32 +: 32] == 32'hFFFF_FFFF || ovf_i[i]));
    // R6: an interrupt flag only appears together with an overflow flag
    a_r6_irq_with_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irqf_i[i]) |-> ovf_i[i]);
  end
endmodule

bind perf_ctr_bank perf_ctr_bank_chk #(.NUM_CTR(NUM_CTR)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .glb_en_i(glb_en),
  .val_we_i(val_we),
  .cnt_i   (cnt_flat),
  .ovf_i   (ovf_vec),
  .irqf_i  (irq_vec)
);

// File: tb/sim_perf_ctr_bank.sv
`timescale 1ns/1ps
module sim_perf_ctr_bank;
  localparam int NC = 4;
  localparam int NG = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NG*16-1:0] evt = '0;
  logic          kmode = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [8:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;
  int            n_run = 0, n_fail = 0;
  logic [31:0]   rv;

  always #5 clk = ~clk;

  perf_ctr_bank #(.NUM_CTR(NC), .NUM_GRP(NG)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .kernel_mode_i(kmode),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [8:0] a_val(int i);  return 9'(32'h080 + 4*i); endfunction
  function automatic logic [8:0] a_ctrl(int i); return 9'(32'h100 + 4*i); endfunction
  function automatic logic [8:0] a_stat(int i); return 9'(32'h180 + 4*i); endfunction
  function automatic logic [31:0] ctl(int grp, logic [15:0] m);
    return {m, 8'(grp), 8'h00};
  endfunction

  task automatic chk(string req_tag, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req_tag, got, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0; d = rdata;
  endtask

  task automatic pulse(int grp, logic [15:0] bits, int n);
    @(negedge clk); evt[grp*16 +: 16] = bits;
    repeat (n) @(negedge clk);
    evt = '0;
  endtask

  initial begin
    #(200000 * 10);
    n_run++; n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(9'h000, rv); chk("R1 global", rv, 0);
    for (int i = 0; i < NC; i++) begin
      rd(a_val(i), rv);  chk("R1 value", rv, 0);
      rd(a_ctrl(i), rv); chk("R1 ctrl", rv, 0);
      rd(a_stat(i), rv); chk("R1 stat", rv, 0);
    end
    chk("R1 irq", 32'(irq), 0);

    // R11 unmapped and out-of-range words
    rd(9'h040, rv);   chk("R11 unmapped", rv, 0);
    rd(a_val(NC), rv); chk("R11 out of range", rv, 0);

    // R2 disabled bank does not count
    wr(a_ctrl(0), ctl(0, 16'h0001));
    pulse(0, 16'h0001, 6);
    rd(a_val(0), rv); chk("R2 disabled", rv, 0);
    wr(9'h000, 32'h1);
    rd(9'h000, rv); chk("R11 global readback", rv, 1);
    pulse(0, 16'h0001, 6);
    wr(a_ctrl(0), 0);
    rd(a_val(0), rv); chk("R2 enabled", rv, 6);

    // R10 stop keeps value, control readback mask
    pulse(0, 16'h0001, 4);
    rd(a_val(0), rv); chk("R10 stopped keeps", rv, 6);
    wr(a_ctrl(2), 32'hFFFF_FFFF);
    rd(a_ctrl(2), rv); chk("R10 ctrl mask", rv, 32'hFFFF_1FF9);
    wr(a_ctrl(2), 0);

    // R3 mask/strobe sweep on group 10, counter 3
    begin
      logic [15:0] ms [6] = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h8000, 16'hFFFF};
      logic [15:0] ss [5] = '{16'h0000, 16'h0001, 16'h0002, 16'h8000, 16'h0006};
      for (int a = 0; a < 6; a++) begin
        for (int b = 0; b < 5; b++) begin
          wr(a_val(3), 0);
          wr(a_ctrl(3), ctl(10, ms[a]));
          pulse(10, ss[b], 5);
          wr(a_ctrl(3), 0);
          rd(a_val(3), rv);
          chk("R3 sweep", rv, ((ms[a] & ss[b]) != 0) ? 32'd5 : 32'd0);
        end
      end
    end
    // R3 strobes in another group are ignored
    wr(a_val(3), 0);
    wr(a_ctrl(3), ctl(10, 16'hFFFF));
    pulse(8, 16'hFFFF, 5);
    wr(a_ctrl(3), 0);
    rd(a_val(3), rv); chk("R3 other group", rv, 0);

    // R4 kernel filter on counter 2, group 2
    wr(a_val(2), 0);
    kmode = 1'b1;
    wr(a_ctrl(2), ctl(2, 16'hFFFF));
    pulse(2, 16'h0040, 4);
    wr(a_ctrl(2), 0);
    rd(a_val(2), rv); chk("R4 kernel blocked", rv, 0);
    wr(a_ctrl(2), ctl(2, 16'hFFFF) | 32'h8);
    pulse(2, 16'h0040, 4);
    wr(a_ctrl(2), 0);
    rd(a_val(2), rv); chk("R4 kernel allowed", rv, 4);
    kmode = 1'b0;
    wr(a_ctrl(2), ctl(2, 16'hFFFF));
    pulse(2, 16'h0040, 4);
    wr(a_ctrl(2), 0);
    rd(a_val(2), rv); chk("R4 user mode", rv, 8);

    // R5 counter 0 on chain code never counts; group 1 strobes ignored
    wr(a_val(0), 0);
    wr(a_ctrl(0), ctl(1, 16'hFFFF));
    pulse(1, 16'hFFFF, 5);
    wr(a_ctrl(0), 0);
    rd(a_val(0), rv); chk("R5 counter0 chain", rv, 0);

    // R5 R6 R8 wrap with interrupt, counter 1 chained
    wr(a_val(0), 32'hFFFF_FFFD);
    wr(a_val(1), 32'd5);
    wr(a_ctrl(1), ctl(1, 16'h0000));
    wr(a_ctrl(0), ctl(0, 16'h0001) | 32'h1);
    pulse(0, 16'h0001, 3);
    wr(a_ctrl(0), 0);
    wr(a_ctrl(1), 0);
    rd(a_val(0), rv); chk("R6 wrapped value", rv, 0);
    rd(a_val(1), rv); chk("R5 chained step", rv, 6);
    rd(a_stat(0), rv); chk("R6 stat flags", rv, 32'h11);
    rd(a_stat(1), rv); chk("R6 neighbour stat", rv, 0);
    chk("R8 irq raised", 32'(irq), 1);

    // R7 write-one-to-clear per bit
    wr(a_stat(0), 32'h10);
    rd(a_stat(0), rv); chk("R7 irq bit cleared", rv, 32'h01);
    chk("R8 irq dropped", 32'(irq), 0);
    wr(a_stat(0), 32'h01);
    rd(a_stat(0), rv); chk("R7 ovf cleared", rv, 0);

    // R6 wrap without interrupt enable
    wr(a_val(0), 32'hFFFF_FFFF);
    wr(a_ctrl(0), ctl(0, 16'h0001));
    pulse(0, 16'h0001, 1);
    wr(a_ctrl(0), 0);
    rd(a_stat(0), rv); chk("R6 no inten", rv, 32'h01);
    chk("R8 irq stays low", 32'(irq), 0);
    wr(a_stat(0), 32'h11);

    // R9 write wins over increment while counting
    wr(a_val(0), 0);
    wr(a_ctrl(0), ctl(0, 16'h0001));
    @(negedge clk); evt[0] = 1'b1;
    repeat (3) @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a_val(0); wdata = 32'd100;
    @(negedge clk); req = 1'b0; we = 1'b0; evt = '0;
    rd(a_val(0), rv); chk("R9 write wins", rv, 100);

    // R9 write at all-ones hides the wrap
    wr(a_val(0), 32'hFFFF_FFFF);
    wr(a_ctrl(0), ctl(0, 16'h0001) | 32'h1);
    @(negedge clk);
    evt[0] = 1'b1; req = 1'b1; we = 1'b1; addr = a_val(0); wdata = 32'd7;
    @(negedge clk); req = 1'b0; we = 1'b0; evt = '0;
    wr(a_ctrl(0), 0);
    rd(a_val(0), rv);  chk("R9 value at wrap", rv, 7);
    rd(a_stat(0), rv); chk("R9 no overflow", rv, 0);
    chk("R9 no irq", 32'(irq), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule